// File: doc/BRIEF.md
# Serializing Pixel Port with Per-Channel Color Lookup

This block sits between a frame buffer and three video converters. It takes pixel words from a wide input port, turns them into a stream of one pixel per pixel-clock cycle, and sends each pixel through three 256-entry tables, one for red, one for green and one for blue. The result is one 10-bit code per channel. A blank/sync pair travels through the same pipeline, so it stays aligned with the codes. The codes are forced to zero while the delayed blank is active.

A load strobe captures two 24-bit words, port A and port B. In single-rate mode only port A is used, and one pixel is taken on each load. In double-rate mode a load captures both words. Port A is presented first and port B on the following clock. Pixels can be read as 24-bit true color, 15-bit true color, or 8-bit indexed color. In indexed mode one selectable input byte addresses all three tables. A mask is ANDed with every index before the lookup.

A host loads the tables over an 8-bit bus in two steps: the upper byte first, then the two low bits. The finished entry is held back until blanking, so it never lands while active pixels are being fetched. A host read returns the stored entry.

Top module: `pixmux_clut`

## Requirements
- R1: After reset the color outputs are zero, blank_o is 1, sync_o is 0 and hst_rdata_o is zero.
- R2: mode_i = 0 is 24-bit true color, and mode_i = 3 behaves the same way. Pixel bits [23:16], [15:8] and [7:0] index the red, green and blue tables. The codes appear at the outputs three rising edges after the edge that captured the pixel.
- R3: When mux2_i = 0, each load_i edge captures a new pixel from port A, and port B has no effect.
- R4: When mux2_i = 1, a load_i edge captures port A and port B. Port A is output first. Port B follows from the next edge, provided that edge has no load.
- R5: mode_i = 1 is 15-bit color. The pixel fields [14:10] (red), [9:5] (green) and [4:0] (blue) each become the upper 5 bits of an 8-bit index whose low 3 bits are zero.
- R6: mode_i = 2 is indexed color. idx_sel_i chooses the index byte: 0 selects [23:16], 1 selects [15:8], 2 or 3 selects [7:0]. The chosen byte indexes all three tables.
- R7: mask_i is ANDed bitwise with every index before the lookup.
- R8: A host write with hst_lo_i = 0 stores hst_wdata_i as entry bits [9:2]. A following write with hst_lo_i = 1 supplies bits [1:0] from hst_wdata_i[1:0] and queues the entry. hst_chan_i selects the table: 0 red, 1 green, 2 blue. hst_re_i returns the addressed entry on hst_rdata_o after the next edge, and the value holds until the next read.
- R9: A queued entry is written on the first edge at which blank_i = 1. A read taken while blank_i = 0 returns the previously stored value.
- R10: blank_o and sync_o equal blank_i and sync_i delayed by three edges, and all color codes are zero while blank_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load strobe for the pixel words |
| mux2_i | input | 1 | 1 = two pixels per load, 0 = one pixel per load |
| mode_i | input | 2 | Pixel format: 0/3 24-bit, 1 15-bit, 2 indexed |
| idx_sel_i | input | 2 | Index byte select for indexed mode |
| mask_i | input | 8 | Index mask |
| pix_a_i | input | 24 | First pixel word |
| pix_b_i | input | 24 | Second pixel word |
| blank_i | input | 1 | Blank, sampled per pixel |
| sync_i | input | 1 | Sync, sampled per pixel |
| hst_we_i | input | 1 | Host write strobe |
| hst_lo_i | input | 1 | 0 = upper byte, 1 = low bits with commit |
| hst_re_i | input | 1 | Host read strobe |
| hst_chan_i | input | 2 | Host table select |
| hst_addr_i | input | 8 | Host table address |
| hst_wdata_i | input | 8 | Host write data |
| hst_rdata_o | output | 10 | Host read data |
| red_o | output | 10 | Red code |
| green_o | output | 10 | Green code |
| blue_o | output | 10 | Blue code |
| blank_o | output | 1 | Delayed blank |
| sync_o | output | 1 | Delayed sync |

## Verification
Most internal faults show up on the colour outputs exactly three edges after the pixel that exposes them:
- A wrong serializer state, such as a lost or repeated port-B word, shows up as the wrong code on the cycle after a load.
- An index-forming fault, such as a wrong field, justification, channel select or mask, gives the wrong table entry on that same cycle.

Table faults surface only when the affected entry is read:
- A pending write that lands during active video, or never lands, makes a later host read or the next lookup of that address differ from the stored model.

Blank and sync misalignment appears as a stray non-zero code at a line edge, or as a phase error on sync_o.

// File: rtl/pixmux_pkg.sv
package pixmux_pkg;
  typedef enum logic [1:0] {
    PM_TRUE24 = 2'd0,
    PM_TRUE15 = 2'd1,
    PM_INDEX  = 2'd2,
    PM_ALT24  = 2'd3
  } pix_mode_e;

  localparam int unsigned NUM_CH   = 3;
  localparam int unsigned C15_BITS = 5;
endpackage

// File: rtl/pixmux_ser.sv
module pixmux_ser #(
  parameter int unsigned PW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          mux2_i,
  input  logic [PW-1:0] pix_a_i,
  input  logic [PW-1:0] pix_b_i,
  input  logic          blank_i,
  input  logic          sync_i,
  output logic [PW-1:0] pix_o,
  output logic          blank_o,
  output logic          sync_o
);
  logic [PW-1:0] b_q;
  logic          b_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o   <= '0;
      b_q     <= '0;
      b_v     <= 1'b0;
      blank_o <= 1'b1;
      sync_o  <= 1'b0;
    end else begin
      blank_o <= blank_i;
      sync_o  <= sync_i;
      if (load_i) begin
        pix_o <= pix_a_i;
        b_q   <= pix_b_i;
        b_v   <= mux2_i;
      end else if (b_v) begin
        pix_o <= b_q;
        b_v   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pixmux_idx.sv
module pixmux_idx import pixmux_pkg::*; #(
  parameter  int unsigned IW = 8,
  localparam int unsigned PW = NUM_CH * IW
) (
  input  logic [PW-1:0]             pix_i,
  input  logic [1:0]                mode_i,
  input  logic [1:0]                sel_i,
  input  logic [IW-1:0]             mask_i,
  output logic [NUM_CH-1:0][IW-1:0] idx_o
);
  pix_mode_e   mode;
  logic [IW-1:0] ix;

  assign mode = pix_mode_e'(mode_i);

  always_comb begin
    unique case (sel_i)
      2'd0:    ix = pix_i[2*IW +: IW];
      2'd1:    ix = pix_i[IW +: IW];
      default: ix = pix_i[0 +: IW];
    endcase
  end

  // channel 0 = red (top field), 2 = blue (bottom field)
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [IW-1:0] raw;
    always_comb begin
      unique case (mode)
        PM_TRUE15: raw = {pix_i[(NUM_CH-1-c)*C15_BITS +: C15_BITS], {(IW-C15_BITS){1'b0}}};
        PM_INDEX:  raw = ix;
        default:   raw = pix_i[(NUM_CH-1-c)*IW +: IW];
      endcase
      idx_o[c] = raw & mask_i;
    end
  end
endmodule

// File: rtl/pixmux_ram.sv
module pixmux_ram #(
  parameter  int unsigned IW = 8,
  parameter  int unsigned CW = 10,
  localparam int unsigned DEPTH = 1 << IW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] wa_i,
  input  logic [CW-1:0] wd_i,
  input  logic [IW-1:0] pa_i,
  output logic [CW-1:0] pd_o,
  input  logic          hre_i,
  input  logic [IW-1:0] ha_i,
  output logic [CW-1:0] hd_o
);
  logic [CW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[wa_i] <= wd_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_o <= '0;
      hd_o <= '0;
    end else begin
      pd_o <= mem[pa_i];
      if (hre_i) hd_o <= mem[ha_i];
    end
  end
endmodule

// File: rtl/pixmux_clut.sv
module pixmux_clut import pixmux_pkg::*; #(
  parameter  int unsigned IW = 8,
  parameter  int unsigned CW = 10,
  parameter  int unsigned HW = 8,
  localparam int unsigned PW = NUM_CH * IW,
  localparam int unsigned LW = CW - HW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          mux2_i,
  input  logic [1:0]    mode_i,
  input  logic [1:0]    idx_sel_i,
  input  logic [IW-1:0] mask_i,
  input  logic [PW-1:0] pix_a_i,
  input  logic [PW-1:0] pix_b_i,
  input  logic          blank_i,
  input  logic          sync_i,
  input  logic          hst_we_i,
  input  logic          hst_lo_i,
  input  logic          hst_re_i,
  input  logic [1:0]    hst_chan_i,
  input  logic [IW-1:0] hst_addr_i,
  input  logic [HW-1:0] hst_wdata_i,
  output logic [CW-1:0] hst_rdata_o,
  output logic [CW-1:0] red_o,
  output logic [CW-1:0] green_o,
  output logic [CW-1:0] blue_o,
  output logic          blank_o,
  output logic          sync_o
);
  logic [PW-1:0]             pix_s1;
  logic                      blank_s1, sync_s1;
  logic [NUM_CH-1:0][IW-1:0] idx_c, idx_s2;
  logic                      blank_s2, sync_s2, blank_s3, sync_s3;
  logic [NUM_CH-1:0][CW-1:0] pd, hd;

  logic [HW-1:0] hi_q;
  logic          pend_v;
  logic [1:0]    pend_ch, rd_ch_q;
  logic [IW-1:0] pend_a;
  logic [CW-1:0] pend_d;
  logic          commit;

  pixmux_ser #(.PW(PW)) ser_i (
    .clk_i, .rst_ni, .load_i, .mux2_i, .pix_a_i, .pix_b_i, .blank_i, .sync_i,
    .pix_o(pix_s1), .blank_o(blank_s1), .sync_o(sync_s1)
  );

  pixmux_idx #(.IW(IW)) idx_i (
    .pix_i(pix_s1), .mode_i, .sel_i(idx_sel_i), .mask_i, .idx_o(idx_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_s2   <= '0;
      blank_s2 <= 1'b1;
      sync_s2  <= 1'b0;
      blank_s3 <= 1'b1;
      sync_s3  <= 1'b0;
    end else begin
      idx_s2   <= idx_c;
      blank_s2 <= blank_s1;
      sync_s2  <= sync_s1;
      blank_s3 <= blank_s2;
      sync_s3  <= sync_s2;
    end
  end

  // host: upper byte staged, low bits queue the entry, applied during blank
  assign commit = pend_v & blank_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= '0;
      pend_v  <= 1'b0;
      pend_ch <= '0;
      pend_a  <= '0;
      pend_d  <= '0;
      rd_ch_q <= '0;
    end else begin
      if (hst_we_i && !hst_lo_i) hi_q <= hst_wdata_i;
      if (hst_we_i && hst_lo_i) begin
        pend_v  <= 1'b1;
        pend_ch <= hst_chan_i;
        pend_a  <= hst_addr_i;
        pend_d  <= {hi_q, hst_wdata_i[LW-1:0]};
      end else if (commit) begin
        pend_v  <= 1'b0;
      end
      if (hst_re_i) rd_ch_q <= hst_chan_i;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_tab
    pixmux_ram #(.IW(IW), .CW(CW)) ram_i (
      .clk_i, .rst_ni,
      .we_i (commit && (pend_ch == 2'(c))),
      .wa_i (pend_a),
      .wd_i (pend_d),
      .pa_i (idx_s2[c]),
      .pd_o (pd[c]),
      .hre_i(hst_re_i && (hst_chan_i == 2'(c))),
      .ha_i (hst_addr_i),
      .hd_o (hd[c])
    );
  end

  always_comb begin
    unique case (rd_ch_q)
      2'd0:    hst_rdata_o = hd[0];
      2'd1:    hst_rdata_o = hd[1];
      2'd2:    hst_rdata_o = hd[2];
      default: hst_rdata_o = '0;
    endcase
  end

  assign red_o   = blank_s3 ? '0 : pd[0];
  assign green_o = blank_s3 ? '0 : pd[1];
  assign blue_o  = blank_s3 ? '0 : pd[2];
  assign blank_o = blank_s3;
  assign sync_o  = sync_s3;
endmodule

// File: rtl/pixmux_clut_chk.sv
module pixmux_clut_chk #(
  parameter int unsigned IW = 8,
  parameter int unsigned CW = 10
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               blank_i,
  input logic               sync_i,
  input logic [IW-1:0]      mask_i,
  input logic               hst_re_i,
  input logic [CW-1:0]      hst_rdata_o,
  input logic [CW-1:0]      red_o,
  input logic [CW-1:0]      green_o,
  input logic [CW-1:0]      blue_o,
  input logic               blank_o,
  input logic               sync_o,
  input logic [2:0][IW-1:0] idx_s2_i
);
  logic [1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cyc_q <= '0;
    else if (cyc_q != 2'd3)   cyc_q <= cyc_q + 2'd1;
  end

  AST_BLANK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_o |-> (red_o == '0 && green_o == '0 && blue_o == '0)); // R10

  AST_BLANK_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd3) |-> (blank_o == $past(blank_i, 3))); // R10

  AST_SYNC_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd3) |-> (sync_o == $past(sync_i, 3))); // R10

  AST_MASK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != 2'd0 && $past(mask_i) == '0) |-> (idx_s2_i == '0)); // R7

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != 2'd0 && !$past(hst_re_i)) |-> $stable(hst_rdata_o)); // R8
endmodule

bind pixmux_clut pixmux_clut_chk #(.IW(IW), .CW(CW)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .blank_i    (blank_i),
  .sync_i     (sync_i),
  .mask_i     (mask_i),
  .hst_re_i   (hst_re_i),
  .hst_rdata_o(hst_rdata_o),
  .red_o      (red_o),
  .green_o    (green_o),
  .blue_o     (blue_o),
  .blank_o    (blank_o),
  .sync_o     (sync_o),
  .idx_s2_i   (idx_s2)
);

// File: tb/pixmux_clut_tb.sv
`timescale 1ns/1ps
module pixmux_clut_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic load, mux2, blank, sync, h_we, h_lo, h_re;
  logic [1:0] mode_r, sel_r, h_chan;
  logic [7:0] mask_r, h_addr, h_data;
  logic [23:0] pa, pb;
  logic [9:0] rdata, red, green, blue;
  logic blank_o, sync_o;

  always #4 clk = ~clk;

  pixmux_clut dut_i (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .mux2_i(mux2), .mode_i(mode_r),
    .idx_sel_i(sel_r), .mask_i(mask_r), .pix_a_i(pa), .pix_b_i(pb),
    .blank_i(blank), .sync_i(sync), .hst_we_i(h_we), .hst_lo_i(h_lo),
    .hst_re_i(h_re), .hst_chan_i(h_chan), .hst_addr_i(h_addr),
    .hst_wdata_i(h_data), .hst_rdata_o(rdata), .red_o(red), .green_o(green),
    .blue_o(blue), .blank_o(blank_o), .sync_o(sync_o)
  );

  int checks = 0, fails = 0;
  logic [9:0] tab [3][256];

  // host shadow (applied at the next step's drive point)
  logic n_we = 0, n_lo = 0, n_re = 0;
  logic [1:0] n_ch = 0;
  logic [7:0] n_ad = 0, n_dt = 0;

  // bench model state
  logic [23:0] cur = 0, pbq = 0;
  logic hb = 0;
  logic pend = 0;
  logic [1:0] pch = 0;
  logic [7:0] pad = 0, hi_m = 0;
  logic [9:0] pdat = 0;
  logic [31:0] e0, e1, e2;
  bit v0 = 0, v1 = 0, v2 = 0;
  string t0 = "", t1 = "", t2 = "", pix_tag = "R2", rd_tag = "R8";
  bit rdp = 0;
  logic [9:0] exp_rd;
  string rdp_tag = "";

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] cidx(input logic [23:0] p, input int c);
    logic [7:0] r;
    case (mode_r)
      2'd1: r = {p[(2-c)*5 +: 5], 3'b000};
      2'd2: case (sel_r)
              2'd0: r = p[23:16];
              2'd1: r = p[15:8];
              default: r = p[7:0];
            endcase
      default: r = p[(2-c)*8 +: 8];
    endcase
    return r & mask_r;
  endfunction

  function automatic logic [29:0] look(input logic [23:0] p);
    return {tab[0][cidx(p,0)], tab[1][cidx(p,1)], tab[2][cidx(p,2)]};
  endfunction

  task automatic step(input bit ld, input logic [23:0] a, input logic [23:0] b,
                      input bit bl, input bit sy);
    @(negedge clk);
    if (v2) begin
      if (e2[1]) chk({red,green,blue} == e2[31:2], "R10", "blank color",
                     {2'b0,red,green,blue}, {2'b0,e2[31:2]});
      else       chk({red,green,blue} == e2[31:2], t2, "color",
                     {2'b0,red,green,blue}, {2'b0,e2[31:2]});
      chk({blank_o,sync_o} == e2[1:0], "R10", "blank/sync",
          {30'b0,blank_o,sync_o}, {30'b0,e2[1:0]});
    end
    if (rdp) chk(rdata == exp_rd, rdp_tag, "host read", {22'b0,rdata}, {22'b0,exp_rd});
    e2 = e1; v2 = v1; t2 = t1;
    e1 = e0; v1 = v0; t1 = t0;
    load = ld; pa = a; pb = b; blank = bl; sync = sy;
    h_we = n_we; h_lo = n_lo; h_re = n_re; h_chan = n_ch; h_addr = n_ad; h_data = n_dt;
    if (ld) begin cur = a; pbq = b; hb = mux2; end
    else if (hb) begin cur = pbq; hb = 0; end
    e0 = {(bl ? 30'b0 : look(cur)), bl, sy}; v0 = 1; t0 = pix_tag;
    rdp = n_re; rdp_tag = rd_tag;
    exp_rd = (n_ch < 3) ? tab[n_ch][n_ad] : 10'd0;
    if (pend && bl) begin
      if (pch < 3) tab[pch][pad] = pdat;
      pend = 0;
    end
    if (n_we && !n_lo) hi_m = n_dt;
    if (n_we && n_lo) begin pend = 1; pch = n_ch; pad = n_ad; pdat = {hi_m, n_dt[1:0]}; end
  endtask

  task automatic cfg(input logic [1:0] m, input logic [1:0] s,
                     input logic [7:0] mk, input bit mx);
    step(1, 0, 0, 1, 0);
    step(1, 0, 0, 1, 0);
    mode_r = m; sel_r = s; mask_r = mk; mux2 = mx;
  endtask

  task automatic burst(input int n);
    for (int i = 0; i < n; i++) begin
      bit bl = ($urandom % 8) == 0;
      bit sy = $urandom % 2;
      step(1, $urandom, $urandom, bl, sy);
      if (mux2) step(0, $urandom, $urandom, ($urandom % 8) == 0, $urandom % 2);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; load = 0; mux2 = 0; blank = 1; sync = 0; h_we = 0; h_lo = 0; h_re = 0;
    mode_r = 0; sel_r = 0; mask_r = 8'hff; pa = 0; pb = 0; h_chan = 0; h_addr = 0; h_data = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1: reset state
    chk({red,green,blue} == 30'b0, "R1", "colors", {2'b0,red,green,blue}, 0);
    chk(blank_o == 1 && sync_o == 0, "R1", "blank/sync", {30'b0,blank_o,sync_o}, 32'h2);
    chk(rdata == 0, "R1", "rdata", {22'b0,rdata}, 0);

    // load all tables through the 8+2 host sequence during blanking (R8)
    for (int c = 0; c < 3; c++)
      for (int a = 0; a < 256; a++) begin
        logic [9:0] v = 10'($urandom);
        n_we = 1; n_lo = 0; n_ch = 2'(c); n_ad = 8'(a); n_dt = v[9:2];
        step(1, 0, 0, 1, 0);
        n_lo = 1; n_dt = {6'b0, v[1:0]};
        step(1, 0, 0, 1, 0);
      end
    n_we = 0; n_lo = 0;
    step(1, 0, 0, 1, 0);
    rd_tag = "R8";
    for (int i = 0; i < 24; i++) begin
      n_re = 1; n_ch = 2'($urandom % 3); n_ad = 8'($urandom);
      step(1, 0, 0, 1, 0);
    end
    n_re = 0;

    pix_tag = "R2"; cfg(0, 0, 8'hff, 0); burst(150);
    pix_tag = "R2"; cfg(3, 0, 8'hff, 0); burst(40);
    pix_tag = "R3"; cfg(0, 0, 8'hff, 0); burst(60);
    pix_tag = "R4"; cfg(0, 0, 8'hff, 1); burst(100);
    pix_tag = "R5"; cfg(1, 0, 8'hff, 0); burst(80);
    pix_tag = "R5"; cfg(1, 0, 8'hff, 1); burst(40);
    for (int s = 0; s < 4; s++) begin
      pix_tag = "R6"; cfg(2, 2'(s), 8'hff, s[0]); burst(50);
    end
    pix_tag = "R7"; cfg(0, 0, 8'h3c, 0); burst(60);
    pix_tag = "R7"; cfg(2, 1, 8'h00, 1); burst(30);
    pix_tag = "R7"; cfg(1, 0, 8'ha5, 0); burst(40);

    // R9: write queued during active video lands at blanking
    pix_tag = "R9"; rd_tag = "R9"; cfg(0, 0, 8'hff, 0);
    n_we = 1; n_lo = 0; n_ch = 1; n_ad = 8'h99; n_dt = 8'ha5;
    step(1, 24'h101010, 0, 0, 0);
    n_lo = 1; n_dt = 8'h02;
    step(1, 24'h101010, 0, 0, 0);
    n_we = 0; n_lo = 0; n_re = 1;
    for (int i = 0; i < 3; i++) step(1, 24'h101010, 0, 0, 0);
    n_re = 0;
    step(1, 0, 0, 1, 0);
    n_re = 1;
    step(1, 0, 0, 1, 0);
    n_re = 0;
    step(1, 0, 0, 1, 0);
    chk(tab[1][8'h99] == 10'h296, "R9", "model entry", {22'b0,tab[1][8'h99]}, 32'h296);
    step(1, 24'h009900, 0, 0, 0);
    step(1, 24'h009900, 0, 0, 1);

    for (int i = 0; i < 5; i++) step(1, 0, 0, 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule